// File: doc/BRIEF.md
# Write-Once Locking Control Register

This block is a single 32-bit control word for a device's configuration space. It holds a clock spread-spectrum disable, a port-4 disable, and a six-bit oscillator frequency code guarded by a one-shot enable. It also holds three override fields. The first hides a capability link and two base-address readbacks. The second sets the polarity of the port-power pins. The third forces the port-power-control capability flag. The PLL, the oscillator and the pads are outside the block; it only produces the control values that go to them.

The frequency enable bit accepts only the first write that reaches its byte. When the enable becomes 1, the frequency code is frozen and a single-cycle restart strobe goes to the oscillator. The code reaches the PLL select outputs only while the external frequency strap is high. It is also decoded to a frequency in kHz, with a flag for reserved codes. The fields live in two reset domains. The enable, the code and the polarity bit clear only on the global reset. Every other field also clears on the link reset.

Top module: `ucfg_lock_reg`

## Requirements
- R1: Bit 30 (frequency enable) takes its value from the first write with `reg_be[3]` set after a global reset. Later writes leave bit 30 unchanged until the next global reset, even if the first write stored 0.
- R2: While bit 30 reads 1, writes to bits 29:24 (frequency code) have no effect. A write that sets bit 30 and carries a code in the same cycle stores that code.
- R3: With `strap_freq` = 1, `pll_code_o` equals the stored code. With `strap_freq` = 0, `pll_code_o`, `pll_khz_o` and `pll_rsvd_o` are all 0.
- R4: With the strap high, `pll_khz_o` is 20000 + 1000*(code-6) for codes 6..24, 38400 for code 25, and 19000 + 1000*(code-6) for codes 26..37. Every other code gives `pll_khz_o` = 0 and `pll_rsvd_o` = 1.
- R5: `osc_restart_o` is high for exactly one cycle: the first cycle in which bit 30 reads 1. It never fires while bit 30 stays at its value.
- R6: When bit 23 is 1, `cap_next_o`, `bar2_o` and `bar3_o` are 0. Otherwise they pass `cap_next_i`, `bar2_i` and `bar3_i` through unchanged.
- R7: Bit 22 = 0 gives `pwr_act_high_o` = 0 and `pwr_pulldn_en_o` = 1. Bit 22 = 1 gives the reverse.
- R8: `ppc_flag_o` is the inverse of bit 16, `ssc_dis_o` follows bit 31, and `port4_dis_o` follows bit 11.
- R9: With `reg_sel` = 1 and `reg_wr` = 0, `reg_rdata` returns the register. Bits 21:17, 15:12 and 10:0 always read 0 and cannot be written. With `reg_sel` = 0, `reg_rdata` is 0.
- R10: All bits are 0 after the global reset. The link reset clears bits 31, 23, 16 and 11 but leaves bits 30, 29:24 and 22 unchanged.
- R11: A write updates only the bytes whose `reg_be` bit is set. Byte 3 holds bits 31:24, byte 2 holds bits 23, 22 and 16, and byte 1 holds bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| grst_n | input | 1 | Global reset, active low, asynchronous; also used as power-on reset |
| link_rst_n | input | 1 | Link reset, active low, asynchronous |
| reg_sel | input | 1 | Address-decoded access enable |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_be | input | 4 | Byte write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| strap_freq | input | 1 | External strap that lets the frequency code reach the PLL |
| cap_next_i | input | 8 | Capability next-pointer value before override |
| bar2_i | input | 32 | Second-pair low base-address readback before override |
| bar3_i | input | 32 | Second-pair high base-address readback before override |
| cap_next_o | output | 8 | Capability next-pointer readback after override |
| bar2_o | output | 32 | Base-address readback after override |
| bar3_o | output | 32 | Base-address readback after override |
| pll_code_o | output | 6 | PLL frequency select |
| pll_khz_o | output | 16 | Decoded oscillator frequency in kHz |
| pll_rsvd_o | output | 1 | The applied code is reserved |
| osc_restart_o | output | 1 | One-cycle oscillator restart strobe |
| ssc_dis_o | output | 1 | Spread-spectrum disable |
| pwr_act_high_o | output | 1 | Port-power pins active high |
| pwr_pulldn_en_o | output | 1 | Port-power pin pull-downs enabled |
| ppc_flag_o | output | 1 | Port-power-control capability flag |
| port4_dis_o | output | 1 | Port 4 disable |

## Verification
Two functions can fall in the same clock edge: the code write and the lock that the enable applies. The bench provokes this with one write that sets bit 30 and carries a new code. It then judges the result on the readback: the new code must be present, and the restart strobe must appear in the next cycle only. A second write with a different code must then leave the code unchanged. The other meeting point is a link reset and a global reset against the same word. The bench compares which fields survive each reset.

// File: rtl/ucfg_pkg.sv
package ucfg_pkg;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int CODE_W    = 6;
    localparam int KHZ_W     = 16;
    localparam int PTR_W     = 8;

    localparam int POS_SSC   = 31;
    localparam int POS_EN    = 30;
    localparam int POS_CODE  = 24;
    localparam int POS_HIDE  = 23;
    localparam int POS_POL   = 22;
    localparam int POS_PPC   = 16;
    localparam int POS_P4    = 11;

    localparam int CODE_LO   = 6;
    localparam int CODE_HI   = 37;
    localparam int CODE_FRAC = 25;
    localparam int KHZ_BASE  = 20000;
    localparam int KHZ_STEP  = 1000;
    localparam int KHZ_FRAC  = 38400;

    typedef struct packed {
        logic              used;
        logic              en;
        logic [CODE_W-1:0] code;
        logic              restart;
    } freq_st_t;

    typedef struct packed {
        logic ssc;
        logic hide;
        logic ppc_dis;
        logic port4;
    } link_st_t;

    typedef struct packed {
        logic pol;
    } glob_st_t;

    function automatic int code_khz(input logic [CODE_W-1:0] c);
        int v;
        v = int'(c);
        if (v < CODE_LO || v > CODE_HI) return 0;
        if (v == CODE_FRAC)             return KHZ_FRAC;
        if (v < CODE_FRAC)              return KHZ_BASE + (v - CODE_LO) * KHZ_STEP;
        return KHZ_BASE + (v - CODE_LO - 1) * KHZ_STEP;
    endfunction
endpackage

// File: rtl/ucfg_freq_lock.sv
module ucfg_freq_lock
    import ucfg_pkg::*;
(
    input  logic              clk,
    input  logic              grst_n,
    input  logic              wr_stb,
    input  logic              be_hi,
    input  logic              wd_en,
    input  logic [CODE_W-1:0] wd_code,
    output logic              en_o,
    output logic [CODE_W-1:0] code_o,
    output logic              restart_o
);
    freq_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        if (wr_stb && be_hi) begin
            if (!st_q.used) begin
                st_d.used = 1'b1;
                st_d.en   = wd_en;
            end
            if (!st_q.en) begin
                st_d.code = wd_code;
            end
        end
        st_d.restart = st_d.en & ~st_q.en;
    end

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o      = st_q.en;
    assign code_o    = st_q.code;
    assign restart_o = st_q.restart;

    assert_once_R1: assert property (@(posedge clk) disable iff (!grst_n)
        (st_q.used && wr_stb && be_hi) |=> $stable(st_q.en));

    assert_code_locked_R2: assert property (@(posedge clk) disable iff (!grst_n)
        (st_q.en && wr_stb && be_hi) |=> $stable(st_q.code));

    assert_restart_single_R5: assert property (@(posedge clk) disable iff (!grst_n)
        st_q.restart |=> !st_q.restart);

    assert_restart_with_en_R5: assert property (@(posedge clk) disable iff (!grst_n)
        st_q.restart |-> st_q.en);
endmodule

// File: rtl/ucfg_ctrl_fields.sv
module ucfg_ctrl_fields
    import ucfg_pkg::*;
(
    input  logic            clk,
    input  logic            grst_n,
    input  logic            link_rst_n,
    input  logic            wr_stb,
    input  logic [BE_W-1:0] be,
    input  logic            wd_ssc,
    input  logic            wd_hide,
    input  logic            wd_pol,
    input  logic            wd_ppc,
    input  logic            wd_p4,
    output logic            ssc_o,
    output logic            hide_o,
    output logic            pol_o,
    output logic            ppc_dis_o,
    output logic            port4_o
);
    link_st_t ln_d, ln_q;
    glob_st_t gl_d, gl_q;
    logic     any_rst_n;

    assign any_rst_n = grst_n & link_rst_n;

    always_comb begin
        ln_d = ln_q;
        gl_d = gl_q;
        if (wr_stb) begin
            if (be[POS_SSC/8]) ln_d.ssc = wd_ssc;
            if (be[POS_HIDE/8]) begin
                ln_d.hide    = wd_hide;
                ln_d.ppc_dis = wd_ppc;
                gl_d.pol     = wd_pol;
            end
            if (be[POS_P4/8]) ln_d.port4 = wd_p4;
        end
    end

    always_ff @(posedge clk or negedge any_rst_n) begin
        if (!any_rst_n) ln_q <= '0;
        else            ln_q <= ln_d;
    end

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n) gl_q <= '0;
        else         gl_q <= gl_d;
    end

    assign ssc_o     = ln_q.ssc;
    assign hide_o    = ln_q.hide;
    assign pol_o     = gl_q.pol;
    assign ppc_dis_o = ln_q.ppc_dis;
    assign port4_o   = ln_q.port4;

    assert_pol_keeps_link_R10: assert property (@(posedge clk) disable iff (!grst_n)
        (!link_rst_n && !(wr_stb && be[POS_POL/8])) |=> $stable(gl_q.pol));

    assert_link_clears_R10: assert property (@(posedge clk) disable iff (!grst_n)
        !link_rst_n |-> (ln_q == '0));
endmodule

// File: rtl/ucfg_freq_decode.sv
module ucfg_freq_decode
    import ucfg_pkg::*;
(
    input  logic              strap,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] pll_code_o,
    output logic [KHZ_W-1:0]  khz_o,
    output logic              rsvd_o
);
    int khz;

    always_comb begin
        khz        = code_khz(code);
        pll_code_o = strap ? code : '0;
        khz_o      = strap ? KHZ_W'(khz) : '0;
        rsvd_o     = strap && (khz == 0);
    end
endmodule

// File: rtl/ucfg_lock_reg.sv
module ucfg_lock_reg
    import ucfg_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_PTR_W  = PTR_W
) (
    input  logic                  clk,
    input  logic                  grst_n,
    input  logic                  link_rst_n,
    input  logic                  reg_sel,
    input  logic                  reg_wr,
    input  logic [P_DATA_W/8-1:0] reg_be,
    input  logic [P_DATA_W-1:0]   reg_wdata,
    output logic [P_DATA_W-1:0]   reg_rdata,
    input  logic                  strap_freq,
    input  logic [P_PTR_W-1:0]    cap_next_i,
    input  logic [P_DATA_W-1:0]   bar2_i,
    input  logic [P_DATA_W-1:0]   bar3_i,
    output logic [P_PTR_W-1:0]    cap_next_o,
    output logic [P_DATA_W-1:0]   bar2_o,
    output logic [P_DATA_W-1:0]   bar3_o,
    output logic [CODE_W-1:0]     pll_code_o,
    output logic [KHZ_W-1:0]      pll_khz_o,
    output logic                  pll_rsvd_o,
    output logic                  osc_restart_o,
    output logic                  ssc_dis_o,
    output logic                  pwr_act_high_o,
    output logic                  pwr_pulldn_en_o,
    output logic                  ppc_flag_o,
    output logic                  port4_dis_o
);
    logic              wr_stb;
    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic              ssc_q, hide_q, pol_q, ppc_dis_q, p4_q;
    logic [P_DATA_W-1:0] word;

    assign wr_stb = reg_sel & reg_wr;

    ucfg_freq_lock u_freq (
        .clk       (clk),
        .grst_n    (grst_n),
        .wr_stb    (wr_stb),
        .be_hi     (reg_be[POS_EN/8]),
        .wd_en     (reg_wdata[POS_EN]),
        .wd_code   (reg_wdata[POS_CODE +: CODE_W]),
        .en_o      (en_q),
        .code_o    (code_q),
        .restart_o (osc_restart_o)
    );

    ucfg_ctrl_fields u_ctrl (
        .clk        (clk),
        .grst_n     (grst_n),
        .link_rst_n (link_rst_n),
        .wr_stb     (wr_stb),
        .be         (reg_be[BE_W-1:0]),
        .wd_ssc     (reg_wdata[POS_SSC]),
        .wd_hide    (reg_wdata[POS_HIDE]),
        .wd_pol     (reg_wdata[POS_POL]),
        .wd_ppc     (reg_wdata[POS_PPC]),
        .wd_p4      (reg_wdata[POS_P4]),
        .ssc_o      (ssc_q),
        .hide_o     (hide_q),
        .pol_o      (pol_q),
        .ppc_dis_o  (ppc_dis_q),
        .port4_o    (p4_q)
    );

    ucfg_freq_decode u_dec (
        .strap      (strap_freq),
        .code       (code_q),
        .pll_code_o (pll_code_o),
        .khz_o      (pll_khz_o),
        .rsvd_o     (pll_rsvd_o)
    );

    always_comb begin
        word                         = '0;
        word[POS_SSC]                = ssc_q;
        word[POS_EN]                 = en_q;
        word[POS_CODE +: CODE_W]     = code_q;
        word[POS_HIDE]               = hide_q;
        word[POS_POL]                = pol_q;
        word[POS_PPC]                = ppc_dis_q;
        word[POS_P4]                 = p4_q;
        reg_rdata                    = (reg_sel && !reg_wr) ? word : '0;
        cap_next_o                   = hide_q ? '0 : cap_next_i;
        bar2_o                       = hide_q ? '0 : bar2_i;
        bar3_o                       = hide_q ? '0 : bar3_i;
        ssc_dis_o                    = ssc_q;
        pwr_act_high_o               = pol_q;
        pwr_pulldn_en_o              = ~pol_q;
        ppc_flag_o                   = ~ppc_dis_q;
        port4_dis_o                  = p4_q;
    end

    assert_restart_strobe_R5: assert property (@(posedge clk) disable iff (!grst_n)
        osc_restart_o |-> $rose(en_q));

    assert_strap_gate_R3: assert property (@(posedge clk) disable iff (!grst_n)
        (!strap_freq) |-> (pll_khz_o == '0 && !pll_rsvd_o));
endmodule

// File: tb/ucfg_lock_reg_bench.sv
module ucfg_lock_reg_bench;
    logic        clk = 1'b0;
    logic        grst_n = 1'b0, link_rst_n = 1'b1;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        strap_freq = 1'b0;
    logic [7:0]  cap_next_i = 8'h5C, cap_next_o;
    logic [31:0] bar2_i = 32'hDEAD_BEEF, bar3_i = 32'h1234_5678, bar2_o, bar3_o;
    logic [5:0]  pll_code_o;
    logic [15:0] pll_khz_o;
    logic        pll_rsvd_o, osc_restart_o, ssc_dis_o, pwr_act_high_o;
    logic        pwr_pulldn_en_o, ppc_flag_o, port4_dis_o;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ucfg_lock_reg u_ucfg_lock_reg (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_sel = 1; reg_wr = 1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; reg_be = '0; reg_wdata = '0;
    endtask

    task automatic rd(output logic [31:0] d);
        reg_sel = 1; reg_wr = 0;
        #1 d = reg_rdata;
        reg_sel = 0;
        #1;
    endtask

    task automatic grst();
        @(negedge clk); grst_n = 0;
        @(negedge clk); grst_n = 1;
        @(negedge clk);
    endtask

    function automatic int exp_khz(input int c);
        if (c < 6 || c > 37) return 0;
        if (c == 25) return 38400;
        return (c < 25) ? 20000 + (c - 6) * 1000 : 20000 + (c - 7) * 1000;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        grst();
        rd(d);
        chk("R10 reset word", d, 32'h0);
        chk("R9 idle rdata", reg_rdata, 32'h0);
        chk("R8 ppc after reset", {31'b0, ppc_flag_o}, 32'h1);
        chk("R7 pulldown after reset", {31'b0, pwr_pulldn_en_o}, 32'h1);
    endtask

    task automatic t_all_ones();
        logic [31:0] d;
        grst();
        wr(32'hFFFF_FFFF, 4'hF);
        chk("R5 restart pulse", {31'b0, osc_restart_o}, 32'h1);
        @(negedge clk);
        chk("R5 restart drop", {31'b0, osc_restart_o}, 32'h0);
        rd(d);
        chk("R9 reserved bits zero", d, 32'hFFC1_0800);
        chk("R8 outputs", {28'b0, ssc_dis_o, ppc_flag_o, port4_dis_o, 1'b0}, 32'hA);
        chk("R7 active high", {30'b0, pwr_act_high_o, pwr_pulldn_en_o}, 32'h2);
    endtask

    task automatic t_byte_strobe();
        logic [31:0] d;
        grst();
        wr(32'hFFFF_FFFF, 4'b0100);
        rd(d);
        chk("R11 byte2 only", d, 32'h00C1_0000);
        wr(32'h4A00_0000, 4'b1000);
        rd(d);
        chk("R11 byte3 after byte2", d, 32'h4AC1_0000);
    endtask

    task automatic t_write_once_zero();
        logic [31:0] d;
        grst();
        wr(32'h0500_0000, 4'b1000);
        wr(32'h7F00_0000, 4'b1000);
        chk("R1 no restart", {31'b0, osc_restart_o}, 32'h0);
        rd(d);
        chk("R1 enable stays 0, code open", d, 32'h3F00_0000);
    endtask

    task automatic t_lock_same_cycle();
        logic [31:0] d;
        grst();
        strap_freq = 1;
        wr(32'h4A00_0000, 4'b1000);
        chk("R2 same-cycle code", {26'b0, pll_code_o}, 32'h0A);
        chk("R5 restart", {31'b0, osc_restart_o}, 32'h1);
        wr(32'h1300_0000, 4'b1000);
        chk("R5 no second pulse", {31'b0, osc_restart_o}, 32'h0);
        rd(d);
        chk("R2 locked", d, 32'h4A00_0000);
        chk("R4 24 MHz", {16'b0, pll_khz_o}, 32'd24000);
        strap_freq = 0;
        #1;
        chk("R3 strap off code", {26'b0, pll_code_o}, 32'h0);
        chk("R3 strap off khz", {16'b0, pll_khz_o}, 32'h0);
    endtask

    task automatic t_sweep();
        grst();
        strap_freq = 1;
        for (int c = 0; c < 64; c++) begin
            wr(32'(c) << 24, 4'b1000);
            chk("R3 code out", {26'b0, pll_code_o}, 32'(c));
            chk("R4 khz", {16'b0, pll_khz_o}, 32'(exp_khz(c)));
            chk("R4 reserved", {31'b0, pll_rsvd_o}, (exp_khz(c) == 0) ? 32'h1 : 32'h0);
        end
        strap_freq = 0;
        #1;
        chk("R3 strap off rsvd", {31'b0, pll_rsvd_o}, 32'h0);
    endtask

    task automatic t_hide();
        grst();
        #1;
        chk("R6 ptr pass", {24'b0, cap_next_o}, 32'h5C);
        chk("R6 bar2 pass", bar2_o, 32'hDEAD_BEEF);
        wr(32'h0080_0000, 4'b0100);
        chk("R6 ptr hidden", {24'b0, cap_next_o}, 32'h0);
        chk("R6 bars hidden", bar2_o | bar3_o, 32'h0);
    endtask

    task automatic t_domains();
        logic [31:0] d;
        grst();
        wr(32'hFFFF_FFFF, 4'hF);
        @(negedge clk); link_rst_n = 0;
        @(negedge clk); link_rst_n = 1;
        @(negedge clk);
        rd(d);
        chk("R10 link reset keeps global fields", d, 32'h7F40_0000);
        wr(32'h0000_0000, 4'b1000);
        rd(d);
        chk("R10 lock survives link reset", d, 32'h7F40_0000);
        grst();
        rd(d);
        chk("R10 global reset clears", d, 32'h0);
    endtask

    initial begin
        t_reset();
        t_all_ones();
        t_byte_strobe();
        t_write_once_zero();
        t_lock_same_cycle();
        t_sweep();
        t_hide();
        t_domains();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule